// File: doc/BRIEF.md
# Operand Extension Word Sequencer

This block turns the 3-bit addressing mode, 3-bit register field and operand size of one instruction operand into a resolved operand descriptor. Where the mode calls for them, it pulls 16-bit extension words from the instruction stream one at a time. A pulse on `start_i` captures the mode, register and size. The block then raises `word_ready_o` once for each extension word the operand needs and accepts a word on every clock edge where `word_valid_i` and `word_ready_o` are both high. One cycle after the last accepted word, it raises `done_o` for a single cycle. When no words are needed, `done_o` comes one cycle after the start.

The descriptor holds several fields: a kind code, the base register field, a 16-bit displacement, the index register type, number and width from an indexed brief word, and a 32-bit absolute or immediate value. It stays on the outputs until the next accepted start. The block does not compute the final address and does not read memory.

The controller has four states. `ST_IDLE` waits for a start. `ST_WORD_A` waits for the first extension word. `ST_WORD_B` waits for the second word of a two-word operand. `ST_DONE` is the single cycle of the done pulse. The transitions are as follows. `ST_IDLE` goes to `ST_WORD_A` on a start that needs words, and to `ST_DONE` on a start that needs none or is illegal. `ST_WORD_A` goes to `ST_WORD_B` on acceptance when two words are owed, and to `ST_DONE` on acceptance when one is owed. `ST_WORD_B` goes to `ST_DONE` on acceptance. `ST_DONE` always returns to `ST_IDLE`.

Top module: `ea_ext_seq`

## Requirements
- R1: After reset, `done_o`, `word_ready_o` and `illegal_o` are low and `kind_o` is 0.
- R2: Modes 000 to 100 fetch no word. The kind equals the mode value: 0 data register, 1 address register, 2 indirect, 3 post-increment, 4 pre-decrement.
- R3: Mode 101 fetches one word, which appears unchanged on `disp_o`. The kind is 5.
- R4: Mode 110 fetches one brief word and gives kind 6. Bit 15 drives `idx_areg_o` (1 means an address register). Bits 14:12 drive `idx_num_o`. Bit 11 drives `idx_long_o`. Bits 7:0, sign-extended to 16 bits, drive `disp_o`.
- R5: Mode 111 with register 000 fetches one word as an absolute short value, `value_o` = {16'h0000, word}, kind 7. Register 001 fetches two words as an absolute long value, first word in bits 31:16, kind 8.
- R6: Mode 111 with register 010 fetches one program-counter displacement word into `disp_o`, kind 9. Register 011 fetches one brief word, unpacked as in R4, with kind 10.
- R7: Mode 111 with register 100 is immediate, kind 11. Size codes are 00 byte, 01 word, 10 long and 11 none. Byte and word fetch one word into `value_o` = {16'h0000, word}. Long fetches two words, first word in bits 31:16.
- R8: Mode 111 with register 101, 110 or 111, or an immediate with size 11, fetches no word. It sets `illegal_o` and kind 15, and ends one cycle after the start.
- R9: `done_o` is a one-cycle pulse. It rises exactly one cycle after the last accepted word, or one cycle after the start when no word is needed.
- R10: `word_ready_o` is high only while a word is still owed. While `word_valid_i` is low, the sequence waits without progress.
- R11: A start that arrives while a sequence is in progress, including its done cycle, has no effect on the descriptor or on the number of words fetched.
- R12: `base_reg_o` is the register field from the start for every kind. Descriptor fields that a kind does not use read 0. All fields hold after `done_o` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin resolving one operand |
| mode_i | input | 3 | Addressing mode field |
| reg_i | input | 3 | Register or sub-mode field |
| size_i | input | 2 | Operand size code (00 byte, 01 word, 10 long, 11 none) |
| word_valid_i | input | 1 | Extension word available |
| word_i | input | 16 | Extension word |
| word_ready_o | output | 1 | Block will take a word this cycle |
| done_o | output | 1 | Descriptor complete (one-cycle pulse) |
| illegal_o | output | 1 | Operand encoding is illegal |
| kind_o | output | 4 | Descriptor kind code |
| base_reg_o | output | 3 | Register field |
| disp_o | output | 16 | Displacement |
| idx_areg_o | output | 1 | Index register is an address register |
| idx_num_o | output | 3 | Index register number |
| idx_long_o | output | 1 | Index register used as long |
| value_o | output | 32 | Absolute address or immediate value |

## Verification
The bound checker watches every cycle for several properties. It checks that `done_o` never lasts two cycles and that `word_ready_o` is high only inside a sequence. At each done pulse it checks that the number of accepted words matches the mode, register and size captured at the first start. It also checks that the kind reported matches that first start, so later starts are ignored, and that an illegal operand consumed no words. Only the bench scenarios can show that the contents of the descriptor are right: the brief word unpacking, the sign extension, the high-word-first assembly of long values, and the zeroing of fields a kind does not use. The same holds for the exact cycle of the done pulse after stalls with `word_valid_i` low.

// File: rtl/ea_seq_pkg.sv
package ea_seq_pkg;

    typedef enum logic [3:0] {
        EK_DREG      = 4'd0,
        EK_AREG      = 4'd1,
        EK_IND       = 4'd2,
        EK_POSTINC   = 4'd3,
        EK_PREDEC    = 4'd4,
        EK_DISP      = 4'd5,
        EK_INDEX     = 4'd6,
        EK_ABS_SHORT = 4'd7,
        EK_ABS_LONG  = 4'd8,
        EK_PC_DISP   = 4'd9,
        EK_PC_INDEX  = 4'd10,
        EK_IMM       = 4'd11,
        EK_BAD       = 4'd15
    } ea_kind_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;
    localparam logic [1:0] SZ_LONG = 2'd2;
    localparam logic [1:0] SZ_NONE = 2'd3;

    // Operand kind from mode, register sub-code and size.
    function automatic ea_kind_e ea_kind(input logic [2:0] m, input logic [2:0] r,
                                         input logic [1:0] s);
        ea_kind_e k;
        case (m)
            3'd0: k = EK_DREG;
            3'd1: k = EK_AREG;
            3'd2: k = EK_IND;
            3'd3: k = EK_POSTINC;
            3'd4: k = EK_PREDEC;
            3'd5: k = EK_DISP;
            3'd6: k = EK_INDEX;
            default: begin
                case (r)
                    3'd0: k = EK_ABS_SHORT;
                    3'd1: k = EK_ABS_LONG;
                    3'd2: k = EK_PC_DISP;
                    3'd3: k = EK_PC_INDEX;
                    3'd4: k = (s == SZ_NONE) ? EK_BAD : EK_IMM;
                    default: k = EK_BAD;
                endcase
            end
        endcase
        return k;
    endfunction

    // Number of extension words owed by an operand.
    function automatic logic [1:0] ea_words(input logic [2:0] m, input logic [2:0] r,
                                            input logic [1:0] s);
        logic [1:0] n;
        case (ea_kind(m, r, s))
            EK_DISP, EK_INDEX, EK_ABS_SHORT,
            EK_PC_DISP, EK_PC_INDEX:        n = 2'd1;
            EK_ABS_LONG:                    n = 2'd2;
            EK_IMM:                         n = (s == SZ_LONG) ? 2'd2 : 2'd1;
            default:                        n = 2'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ea_seq_decode.sv
module ea_seq_decode
    import ea_seq_pkg::*;
(
    input  logic [2:0] mode_i,
    input  logic [2:0] reg_i,
    input  logic [1:0] size_i,
    output ea_kind_e   kind_o,
    output logic [1:0] words_o
);
    always_comb begin
        kind_o  = ea_kind(mode_i, reg_i, size_i);
        words_o = ea_words(mode_i, reg_i, size_i);
    end
endmodule

// File: rtl/ea_seq_brief.sv
module ea_seq_brief #(
    parameter int WORD_W   = 16,
    parameter int SDISP_W  = 8
) (
    input  logic [WORD_W-1:0] word_i,
    output logic              idx_areg_o,
    output logic [2:0]        idx_num_o,
    output logic              idx_long_o,
    output logic [WORD_W-1:0] disp_o
);
    localparam int TYPE_BIT = WORD_W - 1;
    localparam int NUM_LSB  = WORD_W - 4;
    localparam int LONG_BIT = WORD_W - 5;
    localparam int EXT_W    = WORD_W - SDISP_W;

    always_comb begin
        idx_areg_o = word_i[TYPE_BIT];
        idx_num_o  = word_i[NUM_LSB +: 3];
        idx_long_o = word_i[LONG_BIT];
        disp_o     = {{EXT_W{word_i[SDISP_W-1]}}, word_i[SDISP_W-1:0]};
    end
endmodule

// File: rtl/ea_ext_seq.sv
module ea_ext_seq
    import ea_seq_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [2:0]          mode_i,
    input  logic [2:0]          reg_i,
    input  logic [1:0]          size_i,
    input  logic                word_valid_i,
    input  logic [WORD_W-1:0]   word_i,
    output logic                word_ready_o,
    output logic                done_o,
    output logic                illegal_o,
    output logic [3:0]          kind_o,
    output logic [2:0]          base_reg_o,
    output logic [WORD_W-1:0]   disp_o,
    output logic                idx_areg_o,
    output logic [2:0]          idx_num_o,
    output logic                idx_long_o,
    output logic [2*WORD_W-1:0] value_o
);
    localparam int VAL_W = 2 * WORD_W;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WORD_A = 2'd1,
        ST_WORD_B = 2'd2,
        ST_DONE   = 2'd3
    } st_e;

    st_e state_q, state_d;

    ea_kind_e         dec_kind;
    logic [1:0]       dec_words;
    logic             br_areg, br_long;
    logic [2:0]       br_num;
    logic [WORD_W-1:0] br_disp;

    ea_kind_e          kind_q;
    logic [1:0]        words_q;
    logic [2:0]        base_q;
    logic [WORD_W-1:0] disp_q;
    logic              areg_q, long_q;
    logic [2:0]        num_q;
    logic [VAL_W-1:0]  value_q;

    logic take_start, take_word;

    ea_seq_decode u_decode (
        .mode_i (mode_i),
        .reg_i  (reg_i),
        .size_i (size_i),
        .kind_o (dec_kind),
        .words_o(dec_words)
    );

    ea_seq_brief #(.WORD_W(WORD_W), .SDISP_W(8)) u_brief (
        .word_i    (word_i),
        .idx_areg_o(br_areg),
        .idx_num_o (br_num),
        .idx_long_o(br_long),
        .disp_o    (br_disp)
    );

    assign take_start = (state_q == ST_IDLE) && start_i;
    assign take_word  = word_ready_o && word_valid_i;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = (dec_words == 2'd0) ? ST_DONE : ST_WORD_A;
            end
            ST_WORD_A: begin
                if (word_valid_i) state_d = (words_q == 2'd2) ? ST_WORD_B : ST_DONE;
            end
            ST_WORD_B: begin
                if (word_valid_i) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    // Descriptor capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= EK_DREG;
            words_q <= '0;
            base_q  <= '0;
            disp_q  <= '0;
            areg_q  <= 1'b0;
            num_q   <= '0;
            long_q  <= 1'b0;
            value_q <= '0;
        end else if (take_start) begin
            kind_q  <= dec_kind;
            words_q <= dec_words;
            base_q  <= reg_i;
            disp_q  <= '0;
            areg_q  <= 1'b0;
            num_q   <= '0;
            long_q  <= 1'b0;
            value_q <= '0;
        end else if (take_word && state_q == ST_WORD_A) begin
            unique case (kind_q)
                EK_DISP, EK_PC_DISP: disp_q <= word_i;
                EK_INDEX, EK_PC_INDEX: begin
                    disp_q <= br_disp;
                    areg_q <= br_areg;
                    num_q  <= br_num;
                    long_q <= br_long;
                end
                EK_ABS_LONG: value_q[VAL_W-1:WORD_W] <= word_i;
                EK_ABS_SHORT: value_q <= {{WORD_W{1'b0}}, word_i};
                EK_IMM: begin
                    if (words_q == 2'd2) value_q[VAL_W-1:WORD_W] <= word_i;
                    else                 value_q <= {{WORD_W{1'b0}}, word_i};
                end
                default: ;
            endcase
        end else if (take_word && state_q == ST_WORD_B) begin
            value_q[WORD_W-1:0] <= word_i;
        end
    end

    // Outputs.
    always_comb begin
        word_ready_o = (state_q == ST_WORD_A) || (state_q == ST_WORD_B);
        done_o       = (state_q == ST_DONE);
        illegal_o    = (kind_q == EK_BAD);
        kind_o       = kind_q;
        base_reg_o   = base_q;
        disp_o       = disp_q;
        idx_areg_o   = areg_q;
        idx_num_o    = num_q;
        idx_long_o   = long_q;
        value_o      = value_q;
    end
endmodule

// File: rtl/ea_ext_seq_chk.sv
module ea_ext_seq_chk
    import ea_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [2:0] mode_i,
    input logic [2:0] reg_i,
    input logic [1:0] size_i,
    input logic       word_valid_i,
    input logic       word_ready_o,
    input logic       done_o,
    input logic       illegal_o,
    input logic [3:0] kind_o
);
    logic       act_q;
    logic [1:0] acc_q;
    logic [2:0] m_q, r_q;
    logic [1:0] s_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            acc_q <= '0;
            m_q   <= '0;
            r_q   <= '0;
            s_q   <= '0;
        end else if (done_o) begin
            act_q <= 1'b0;
        end else if (start_i && !act_q) begin
            act_q <= 1'b1;
            acc_q <= '0;
            m_q   <= mode_i;
            r_q   <= reg_i;
            s_q   <= size_i;
        end else if (word_valid_i && word_ready_o) begin
            acc_q <= acc_q + 2'd1;
        end
    end

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_ready_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready_o |-> act_q);

    a_r8_illegal_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && illegal_o) |-> (acc_q == 2'd0));

    // R2 through R7: word count follows mode, register and size
    a_r2_word_count: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (acc_q == ea_words(m_q, r_q, s_q)));

    a_r11_first_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (kind_o == 4'(ea_kind(m_q, r_q, s_q))));
endmodule

bind ea_ext_seq ea_ext_seq_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .reg_i       (reg_i),
    .size_i      (size_i),
    .word_valid_i(word_valid_i),
    .word_ready_o(word_ready_o),
    .done_o      (done_o),
    .illegal_o   (illegal_o),
    .kind_o      (kind_o)
);

// File: tb/ea_ext_seq_tb_top.sv
module ea_ext_seq_tb_top;

    typedef struct {
        logic [3:0]  kind;
        logic        ill;
        logic [2:0]  base;
        logic [15:0] disp;
        logic        areg;
        logic [2:0]  num;
        logic        lng;
        logic [31:0] value;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  mode_i = '0;
    logic [2:0]  reg_i = '0;
    logic [1:0]  size_i = '0;
    logic        word_valid_i = 1'b0;
    logic [15:0] word_i = '0;
    logic        word_ready_o, done_o, illegal_o, idx_areg_o, idx_long_o;
    logic [3:0]  kind_o;
    logic [2:0]  base_reg_o, idx_num_o;
    logic [15:0] disp_o;
    logic [31:0] value_o;

    int checks = 0;
    int errors = 0;
    exp_t sb_q[$];

    // 4-unit period: 250 MHz with 1 ns units
    always #2 clk = ~clk;

    ea_ext_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .reg_i(reg_i), .size_i(size_i), .word_valid_i(word_valid_i),
        .word_i(word_i), .word_ready_o(word_ready_o), .done_o(done_o),
        .illegal_o(illegal_o), .kind_o(kind_o), .base_reg_o(base_reg_o),
        .disp_o(disp_o), .idx_areg_o(idx_areg_o), .idx_num_o(idx_num_o),
        .idx_long_o(idx_long_o), .value_o(value_o)
    );

    task automatic check(input bit ok, input string req, input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    function automatic exp_t mk(input logic [3:0] k, input logic [2:0] b, input string req);
        exp_t e;
        e.kind = k; e.ill = (k == 4'd15); e.base = b; e.disp = '0;
        e.areg = 1'b0; e.num = '0; e.lng = 1'b0; e.value = '0; e.req = req;
        return e;
    endfunction

    // Monitor: compare each finished descriptor against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R9", "unexpected done", "no done");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(kind_o === e.kind && illegal_o === e.ill && base_reg_o === e.base &&
                      disp_o === e.disp && idx_areg_o === e.areg && idx_num_o === e.num &&
                      idx_long_o === e.lng && value_o === e.value,
                      e.req,
                      $sformatf("k=%0d il=%b b=%0d d=%h a=%b n=%0d l=%b v=%h", kind_o, illegal_o,
                                base_reg_o, disp_o, idx_areg_o, idx_num_o, idx_long_o, value_o),
                      $sformatf("k=%0d il=%b b=%0d d=%h a=%b n=%0d l=%b v=%h", e.kind, e.ill,
                                e.base, e.disp, e.areg, e.num, e.lng, e.value));
            end
        end
    end

    // Driver: one operand, nw words, gap idle cycles before each word.
    task automatic run(input logic [2:0] m, input logic [2:0] r, input logic [1:0] s,
                       input int nw, input logic [15:0] w0, input logic [15:0] w1,
                       input int gap, input bit poke, input exp_t e);
        sb_q.push_back(e);
        @(negedge clk);
        start_i = 1'b1; mode_i = m; reg_i = r; size_i = s;
        @(negedge clk);
        start_i = 1'b0; mode_i = '0; reg_i = '0; size_i = '0;
        for (int k = 0; k < nw; k++) begin
            for (int g = 0; g < gap; g++) begin
                check(word_ready_o === 1'b1 && done_o === 1'b0, "R10",
                      $sformatf("rdy=%b done=%b", word_ready_o, done_o), "rdy=1 done=0");
                if (poke) begin
                    start_i = 1'b1; mode_i = 3'd0; reg_i = 3'd2; size_i = 2'd0;  // R11
                end
                @(negedge clk);
                start_i = 1'b0;
            end
            check(word_ready_o === 1'b1, "R10", $sformatf("rdy=%b", word_ready_o), "rdy=1");
            word_valid_i = 1'b1;
            word_i = (k == 0) ? w0 : w1;
            @(negedge clk);
            word_valid_i = 1'b0;
        end
        check(done_o === 1'b1, "R9", $sformatf("done=%b", done_o), "done=1");
        if (poke) start_i = 1'b1;  // R11: start in the done cycle is ignored
        @(negedge clk);
        start_i = 1'b0;
        check(done_o === 1'b0 && word_ready_o === 1'b0, "R9",
              $sformatf("done=%b rdy=%b", done_o, word_ready_o), "done=0 rdy=0");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        exp_t e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done_o === 1'b0 && word_ready_o === 1'b0 && illegal_o === 1'b0 && kind_o === 4'd0,
              "R1", $sformatf("d=%b r=%b i=%b k=%0d", done_o, word_ready_o, illegal_o, kind_o),
              "all zero");

        // R2: register modes, no words
        for (int m = 0; m < 5; m++) begin
            e = mk(4'(m), 3'(m + 1), "R2");
            run(3'(m), 3'(m + 1), 2'd1, 0, 16'h0, 16'h0, 0, 1'b0, e);
        end

        // R3: displacement with stall
        e = mk(4'd5, 3'd4, "R3"); e.disp = 16'h8123;
        run(3'd5, 3'd4, 2'd1, 1, 16'h8123, 16'h0, 2, 1'b0, e);

        // R4: brief words, negative and positive displacement
        e = mk(4'd6, 3'd1, "R4"); e.areg = 1'b1; e.num = 3'd3; e.lng = 1'b1; e.disp = 16'hFFF0;
        run(3'd6, 3'd1, 2'd0, 1, 16'hB8F0, 16'h0, 0, 1'b0, e);
        e = mk(4'd6, 3'd6, "R4"); e.num = 3'd2; e.disp = 16'h0005;
        run(3'd6, 3'd6, 2'd2, 1, 16'h2005, 16'h0, 1, 1'b0, e);

        // R5: absolute short and long
        e = mk(4'd7, 3'd0, "R5"); e.value = 32'h0000_1234;
        run(3'd7, 3'd0, 2'd1, 1, 16'h1234, 16'h0, 0, 1'b0, e);
        e = mk(4'd8, 3'd1, "R5"); e.value = 32'hA5A5_5A5A;
        run(3'd7, 3'd1, 2'd0, 2, 16'hA5A5, 16'h5A5A, 1, 1'b0, e);

        // R6: program-counter displacement and indexed
        e = mk(4'd9, 3'd2, "R6"); e.disp = 16'hFFFE;
        run(3'd7, 3'd2, 2'd1, 1, 16'hFFFE, 16'h0, 0, 1'b0, e);
        e = mk(4'd10, 3'd3, "R6"); e.num = 3'd7; e.lng = 1'b1; e.disp = 16'hFF80;
        run(3'd7, 3'd3, 2'd1, 1, 16'h7F80, 16'h0, 0, 1'b0, e);

        // R7: immediates of each size
        e = mk(4'd11, 3'd4, "R7"); e.value = 32'h0000_00AB;
        run(3'd7, 3'd4, 2'd0, 1, 16'h00AB, 16'h0, 0, 1'b0, e);
        e = mk(4'd11, 3'd4, "R7"); e.value = 32'h0000_BEEF;
        run(3'd7, 3'd4, 2'd1, 1, 16'hBEEF, 16'h0, 0, 1'b0, e);
        e = mk(4'd11, 3'd4, "R7"); e.value = 32'hDEAD_BEEF;
        run(3'd7, 3'd4, 2'd2, 2, 16'hDEAD, 16'hBEEF, 2, 1'b0, e);

        // R8: illegal encodings
        e = mk(4'd15, 3'd4, "R8");
        run(3'd7, 3'd4, 2'd3, 0, 16'h0, 16'h0, 0, 1'b0, e);
        for (int r = 5; r < 8; r++) begin
            e = mk(4'd15, 3'(r), "R8");
            run(3'd7, 3'(r), 2'd1, 0, 16'h0, 16'h0, 0, 1'b0, e);
        end

        // R11: starts during fetch and done cycle ignored
        e = mk(4'd8, 3'd1, "R11"); e.value = 32'h0102_0304;
        run(3'd7, 3'd1, 2'd2, 2, 16'h0102, 16'h0304, 3, 1'b1, e);

        // R12: descriptor holds after done
        repeat (3) @(negedge clk);
        check(value_o === 32'h0102_0304 && kind_o === 4'd8 && disp_o === 16'h0, "R12",
              $sformatf("v=%h k=%0d d=%h", value_o, kind_o, disp_o), "v=01020304 k=8 d=0000");

        check(sb_q.size() == 0, "R9", $sformatf("pending=%0d", sb_q.size()), "pending=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule